// File: doc/BRIEF.md
# Four-Port Memory Self-Test Sequencer

The block is a built-in self-test controller for a small synchronous RAM with four ports. Once started, it runs a fixed series of phases. Port 1 writes a checkerboard, and all four ports read it back. Port 1 then writes the inverse checkerboard, and all four ports read that back. After that comes a unique-address phase. This phase runs three times: first with port 2 as the writer, then port 3, then port 4. For every phase the block drives address, write data, write enable and read enable for each port. It checks each returned word against the expected pattern.

The phase in progress is reported as a 6-bit state code. Because the codes of the unique-address phase are the same for every writer, a separate writer-index output tells the three repetitions apart. When a mismatch occurs, the block captures the details of the first one and carries on to the end of the sequence. It then raises done, and raises pass only if every compare matched. A 2-bit mode input selects between free running and a debug mode. In debug mode the sequencer halts after every state until a step pulse arrives.

Top module: `mbist_seq`

## Requirements
- R1: After reset, stateCode is 000000 and busy, done, pass, fail, memWe and memRe are all zero.
- R2: A start pulse while idle or done runs these state codes in this order: 000001 (port 1 writes checkerboard), 001001 (all-ports read of checkerboard), 001000 (port 1 writes inverse checkerboard), 011000 (all-ports read of inverse). Next come three passes of 011001, 011011, 011010, 011110, 011111, 011101, with wrPort equal to 1, 2 and 3 (ports 2, 3 and 4). The sequence ends on 110010.
- R3: In a checkerboard write, each address a from 0 upward is written exactly once through port 1 (memWe bit 0). The data is bit a[0] XOR a[COL_W] replicated across the word. The inverse phase writes the complement.
- R4: Each unique-address write state writes every address once, in ascending order, through port wrPort+1. In order, the data is all zeros, the address zero-extended or truncated to the data width, all ones, and the bitwise inverse of that address value.
- R5: Each all-ports read state issues reads with memRe only. It covers every address in ascending order through port 1, then port 2, port 3 and port 4. Port p uses slice p-1 of the memAddr/memWdata/memRdata buses and bit p-1 of memWe/memRe.
- R6: In any cycle at most one of the eight memWe/memRe bits is high.
- R7: Read data is compared one cycle after its address is issued. On the first mismatch after start, the block latches failAddr, failPort (0 means port 1), failState (the read state code) and failData (the word read), and sets fail. Later mismatches leave the capture unchanged.
- R8: done rises only after the last compare has been made, with stateCode 110010. Once done is high, pass equals NOT fail.
- R9: With mode 01, the sequencer halts after the last access of each state. stateCode holds and no enables are driven until a one-cycle step pulse, which moves it to the next state.
- R10: Mode values 10 and 11 behave as 00: the sequence runs without halting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a test run when idle or done |
| mode | input | 2 | 00 run, 01 debug halt per state, 10/11 as 00 |
| step | input | 1 | Releases a debug halt |
| memAddr | output | 4*ADDR_W | Per-port address, port 1 in the low slice |
| memWdata | output | 4*DATA_W | Per-port write data |
| memWe | output | 4 | Per-port write enable |
| memRe | output | 4 | Per-port read enable |
| memRdata | input | 4*DATA_W | Per-port read data, valid one cycle after memRe |
| stateCode | output | 6 | Current state code |
| wrPort | output | 2 | Unique-address writer index, 1..3 for ports 2..4 |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test complete, all compares made |
| pass | output | 1 | Done with no mismatch |
| fail | output | 1 | A mismatch has been seen |
| failAddr | output | ADDR_W | Address of first mismatch |
| failPort | output | 2 | Port of first mismatch, 0-based |
| failState | output | 6 | State code of first mismatch |
| failData | output | DATA_W | Data read at first mismatch |

## Verification
The assertions rely on the RAM returning read data exactly one cycle after memRe. They also rely on step being a single-cycle pulse that is given only while the sequencer is halted. Start is assumed to be pulsed only when the block is idle or done. The bench model answers every read on the following edge. The bench issues start only after done, and drives step for exactly one cycle, after waiting long enough for the longest state to finish.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  localparam int NPORTS = 4;

  typedef enum logic [5:0] {
    ST_IDLE     = 6'b000000,
    ST_CHK_W    = 6'b000001,
    ST_CHK_R    = 6'b001001,
    ST_NCHK_W   = 6'b001000,
    ST_NCHK_R   = 6'b011000,
    ST_UA_ZERO  = 6'b011001,
    ST_UA_ADDR  = 6'b011011,
    ST_UA_RD    = 6'b011010,
    ST_UA_ONES  = 6'b011110,
    ST_UA_NADDR = 6'b011111,
    ST_UA_NRD   = 6'b011101,
    ST_DONE     = 6'b110010
  } state_e;

  typedef enum logic [2:0] {
    PAT_CHK, PAT_NCHK, PAT_ZERO, PAT_ADDR, PAT_ONES, PAT_NADDR
  } pat_e;

  typedef struct packed {
    logic       we;
    logic       re;
    logic [1:0] port;
    pat_e       pat;
    logic       clrFail;
  } strobe_t;
endpackage

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              step,
  output state_e            state,
  output logic [1:0]        uaPort,
  output logic [ADDR_W-1:0] addr,
  output strobe_t           stb
);
  localparam int CNT_W = ADDR_W + 2;

  logic [CNT_W-1:0] cnt;
  logic halted, isRead, isWrite, lastOp, debugMode, startOk;
  state_e nxt;
  pat_e pat;

  assign debugMode = (mode == 2'b01);
  assign startOk   = start && (state == ST_IDLE || state == ST_DONE);

  always_comb begin
    isRead  = 1'b0;
    isWrite = 1'b0;
    nxt     = ST_IDLE;
    pat     = PAT_ZERO;
    case (state)
      ST_CHK_W:    begin isWrite = 1'b1; nxt = ST_CHK_R;    pat = PAT_CHK;   end
      ST_CHK_R:    begin isRead  = 1'b1; nxt = ST_NCHK_W;   pat = PAT_CHK;   end
      ST_NCHK_W:   begin isWrite = 1'b1; nxt = ST_NCHK_R;   pat = PAT_NCHK;  end
      ST_NCHK_R:   begin isRead  = 1'b1; nxt = ST_UA_ZERO;  pat = PAT_NCHK;  end
      ST_UA_ZERO:  begin isWrite = 1'b1; nxt = ST_UA_ADDR;  pat = PAT_ZERO;  end
      ST_UA_ADDR:  begin isWrite = 1'b1; nxt = ST_UA_RD;    pat = PAT_ADDR;  end
      ST_UA_RD:    begin isRead  = 1'b1; nxt = ST_UA_ONES;  pat = PAT_ADDR;  end
      ST_UA_ONES:  begin isWrite = 1'b1; nxt = ST_UA_NADDR; pat = PAT_ONES;  end
      ST_UA_NADDR: begin isWrite = 1'b1; nxt = ST_UA_NRD;   pat = PAT_NADDR; end
      ST_UA_NRD:   begin
        isRead = 1'b1;
        pat    = PAT_NADDR;
        nxt    = (uaPort == 2'd3) ? ST_DONE : ST_UA_ZERO;
      end
      ST_DONE:     nxt = ST_DONE;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign lastOp = isRead ? (&cnt) : (&cnt[ADDR_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      uaPort <= 2'd1;
      halted <= 1'b0;
    end else if (startOk) begin
      state  <= ST_CHK_W;
      cnt    <= '0;
      uaPort <= 2'd1;
      halted <= 1'b0;
    end else if ((halted && step) || (!halted && (isRead || isWrite) && lastOp && !debugMode)) begin
      halted <= 1'b0;
      state  <= nxt;
      cnt    <= '0;
      if (state == ST_UA_NRD && uaPort != 2'd3) uaPort <= uaPort + 2'd1;
    end else if (!halted && (isRead || isWrite)) begin
      if (lastOp) halted <= 1'b1;
      else        cnt    <= cnt + 1'b1;
    end
  end

  assign addr        = cnt[ADDR_W-1:0];
  assign stb.we      = isWrite && !halted;
  assign stb.re      = isRead && !halted;
  assign stb.port    = isRead ? cnt[CNT_W-1:ADDR_W]
                     : ((state == ST_CHK_W || state == ST_NCHK_W) ? 2'd0 : uaPort);
  assign stb.pat     = pat;
  assign stb.clrFail = startOk;

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !step && !start) |=> ($stable(state) && !stb.we && !stb.re));
  p_writer_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    uaPort != 2'd0);
  p_no_rw_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.we && stb.re));
endmodule

// File: rtl/mbist_dp.sv
module mbist_dp
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int COL_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [5:0]               stateCode,
  input  logic [NPORTS*DATA_W-1:0] memRdata,
  output logic [NPORTS*ADDR_W-1:0] memAddr,
  output logic [NPORTS*DATA_W-1:0] memWdata,
  output logic [NPORTS-1:0]        memWe,
  output logic [NPORTS-1:0]        memRe,
  output logic                     pendValid,
  output logic                     fail,
  output logic [ADDR_W-1:0]        failAddr,
  output logic [1:0]               failPort,
  output logic [5:0]               failState,
  output logic [DATA_W-1:0]        failData
);
  function automatic logic [DATA_W-1:0] expVal(pat_e p, logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] av;
    logic cb;
    av = '0;
    for (int i = 0; i < DATA_W; i++) if (i < ADDR_W) av[i] = a[i];
    cb = a[0] ^ a[COL_W];
    case (p)
      PAT_CHK:   return {DATA_W{cb}};
      PAT_NCHK:  return {DATA_W{~cb}};
      PAT_ADDR:  return av;
      PAT_ONES:  return '1;
      PAT_NADDR: return ~av;
      default:   return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] wdata, pendExp, rdSel;
  logic [ADDR_W-1:0] pendAddr;
  logic [1:0] pendPort;
  logic [5:0] pendState;
  logic mismatch;

  assign wdata = expVal(stb.pat, addr);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign memAddr[p*ADDR_W +: ADDR_W]  = addr;
    assign memWdata[p*DATA_W +: DATA_W] = wdata;
    assign memWe[p] = stb.we && (stb.port == p);
    assign memRe[p] = stb.re && (stb.port == p);
  end

  assign rdSel    = memRdata[pendPort*DATA_W +: DATA_W];
  assign mismatch = pendValid && (rdSel != pendExp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendPort  <= '0;
      pendState <= '0;
      pendExp   <= '0;
      fail      <= 1'b0;
      failAddr  <= '0;
      failPort  <= '0;
      failState <= '0;
      failData  <= '0;
    end else begin
      pendValid <= stb.re;
      if (stb.re) begin
        pendAddr  <= addr;
        pendPort  <= stb.port;
        pendState <= stateCode;
        pendExp   <= wdata;
      end
      if (stb.clrFail) begin
        fail <= 1'b0;
      end else if (mismatch && !fail) begin
        fail      <= 1'b1;
        failAddr  <= pendAddr;
        failPort  <= pendPort;
        failState <= pendState;
        failData  <= rdSel;
      end
    end
  end

  p_one_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWe, memRe}));
  p_capture_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !stb.clrFail) |=> (fail && $stable(failAddr) && $stable(failData)));
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int COL_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [1:0]               mode,
  input  logic                     step,
  output logic [4*ADDR_W-1:0]      memAddr,
  output logic [4*DATA_W-1:0]      memWdata,
  output logic [3:0]               memWe,
  output logic [3:0]               memRe,
  input  logic [4*DATA_W-1:0]      memRdata,
  output logic [5:0]               stateCode,
  output logic [1:0]               wrPort,
  output logic                     busy,
  output logic                     done,
  output logic                     pass,
  output logic                     fail,
  output logic [ADDR_W-1:0]        failAddr,
  output logic [1:0]               failPort,
  output logic [5:0]               failState,
  output logic [DATA_W-1:0]        failData
);
  state_e state;
  strobe_t stb;
  logic [ADDR_W-1:0] addr;
  logic pendValid;

  mbist_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .step(step),
    .state(state), .uaPort(wrPort), .addr(addr), .stb(stb)
  );

  mbist_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .stateCode(stateCode),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .pendValid(pendValid), .fail(fail),
    .failAddr(failAddr), .failPort(failPort), .failState(failState),
    .failData(failData)
  );

  assign stateCode = state;
  assign done      = (state == ST_DONE) && !pendValid;
  assign pass      = done && !fail;
  assign busy      = (state != ST_IDLE) && !done;

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && memWe == 4'b0 && memRe == 4'b0));
endmodule

// File: tb/tb_mbist_seq.sv
module tb_mbist_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CW = 2;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, step = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [4*AW-1:0] memAddr;
  logic [4*DW-1:0] memWdata, memRdata;
  logic [3:0] memWe, memRe;
  logic [5:0] stateCode, failState;
  logic [1:0] wrPort, failPort;
  logic busy, done, pass, fail;
  logic [AW-1:0] failAddr;
  logic [DW-1:0] failData;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_seq #(.ADDR_W(AW), .DATA_W(DW), .COL_W(CW)) dut (.*);

  // behavioural four-port RAM with fault injection
  logic [DW-1:0] mem [N];
  logic [DW-1:0] rd [4];
  int fKind = 0, fAddr = 0, fBit = 0, fVal = 0, fPort = 0;
  always @(posedge clk) begin
    for (int p = 0; p < 4; p++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] w, flip;
      a = memAddr[p*AW +: AW];
      w = memWdata[p*DW +: DW];
      flip = '0;
      if (fKind == 1 && a == fAddr) w[fBit] = fVal[0];
      if (fKind == 2 && p == fPort && a == fAddr) flip[fBit] = 1'b1;
      if (memWe[p]) mem[a] <= w;
      if (memRe[p]) rd[p] <= mem[a] ^ flip;
    end
  end
  for (genvar p = 0; p < 4; p++) begin : g_rd
    assign memRdata[p*DW +: DW] = rd[p];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] expCode(int i);
    logic [5:0] ua [6] = '{6'b011001, 6'b011011, 6'b011010, 6'b011110, 6'b011111, 6'b011101};
    case (i)
      0: return 6'b000001;
      1: return 6'b001001;
      2: return 6'b001000;
      3: return 6'b011000;
      22: return 6'b110010;
      default: return ua[(i-4)%6];
    endcase
  endfunction

  function automatic logic [DW-1:0] expData(logic [5:0] code, int a);
    logic [DW-1:0] av;
    logic cb;
    av = DW'(a);
    cb = a[0] ^ a[CW];
    case (code)
      6'b000001, 6'b001001: return {DW{cb}};
      6'b001000, 6'b011000: return {DW{~cb}};
      6'b011001: return '0;
      6'b011011, 6'b011010: return av;
      6'b011110: return '1;
      default:   return ~av;
    endcase
  endfunction

  function automatic bit isRdCode(logic [5:0] c);
    return c == 6'b001001 || c == 6'b011000 || c == 6'b011010 || c == 6'b011101;
  endfunction

  // operation stream monitor
  logic [5:0] prevCode = '0;
  logic [5:0] codeLog [32];
  int nCodes = 0, stepIdx = 0, uaCnt = 0, opErr = 0, ohErr = 0;
  always @(negedge clk) if (rstN) begin
    if ($countones({memWe, memRe}) > 1) ohErr++;
    if (stateCode != prevCode) begin
      if (prevCode != 6'b0 && prevCode != 6'b110010 &&
          stepIdx != (isRdCode(prevCode) ? 4*N : N)) opErr++;
      if (stateCode != 6'b0 && nCodes < 32) begin
        codeLog[nCodes] = stateCode;
        nCodes++;
      end
      if (stateCode == 6'b011001) uaCnt++;
      stepIdx = 0;
      prevCode = stateCode;
    end
    if (memWe != 0 || memRe != 0) begin
      int p, a;
      if (isRdCode(stateCode)) begin
        p = stepIdx / N; a = stepIdx % N;
        if (memRe != (4'b1 << p) || memWe != 0) opErr++;
      end else begin
        p = (stateCode == 6'b000001 || stateCode == 6'b001000) ? 0 : uaCnt;
        a = stepIdx;
        if (memWe != (4'b1 << p) || memRe != 0) opErr++;
        if (memWdata[p*DW +: DW] != expData(stateCode, a)) opErr++;
        if (p > 0 && wrPort != p) opErr++;
      end
      if (memAddr[p*AW +: AW] != AW'(a)) opErr++;
      stepIdx++;
    end
  end

  task automatic kick();
    nCodes = 0; uaCnt = 0; opErr = 0; ohErr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, req, "done reached", done, 1);
  endtask

  task automatic checkRun(input string tag);
    bit seqOk = (nCodes == 23);
    for (int i = 0; i < 23; i++) if (i < nCodes && codeLog[i] != expCode(i)) seqOk = 0;
    chk(seqOk, "R2", {tag, " state order"}, nCodes, 23);
    chk(opErr == 0, "R3 R4 R5", {tag, " access stream"}, opErr, 0);
    chk(ohErr == 0, "R6", {tag, " single enable"}, ohErr, 0);
    chk(stateCode == 6'b110010 && !busy, "R8", {tag, " final code"}, stateCode, 6'b110010);
    chk(pass == !fail, "R8", {tag, " pass vs fail"}, pass, !fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] expD;
    logic cb;
    void'($urandom(32'd4217));
    repeat (3) @(negedge clk);
    chk(stateCode == 0 && !busy && !done && !pass && !fail && memWe == 0 && memRe == 0,
        "R1", "reset state", {stateCode, busy, done, pass, fail}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R8: clean run, mode 00
    kick();
    chk(busy, "R2", "busy after start", busy, 1);
    waitDone("R8");
    checkRun("mode00");
    chk(pass && !fail, "R8", "clean pass", pass, 1);

    // R10: reserved mode 10, clean
    mode = 2'b10;
    kick();
    waitDone("R10");
    checkRun("mode10 R10");
    chk(pass, "R10", "reserved mode passes", pass, 1);

    // R7: stuck-at faults, reserved mode 11
    mode = 2'b11;
    for (int k = 0; k < 3; k++) begin
      fKind = 1; fAddr = $urandom % N; fBit = $urandom % DW; fVal = $urandom % 2;
      kick();
      waitDone("R7");
      checkRun("stuck R10");
      cb = fAddr[0] ^ fAddr[CW];
      if (cb != fVal[0]) begin expD = {DW{cb}}; expD[fBit] = fVal[0];
        chk(failState == 6'b001001, "R7", "stuck state", failState, 6'b001001);
      end else begin expD = {DW{~cb}}; expD[fBit] = fVal[0];
        chk(failState == 6'b011000, "R7", "stuck state", failState, 6'b011000);
      end
      chk(fail && !pass, "R7", "fail flag", fail, 1);
      chk(failAddr == fAddr, "R7", "fail addr", failAddr, fAddr);
      chk(failPort == 0, "R7", "fail port", failPort, 0);
      chk(failData == expD, "R7", "fail data", failData, expD);
    end

    // R7: read fault on one port only
    mode = 2'b00;
    fKind = 2; fAddr = $urandom % N; fBit = $urandom % DW; fPort = 1 + $urandom % 3;
    kick();
    waitDone("R7");
    checkRun("portfault");
    cb = fAddr[0] ^ fAddr[CW];
    expD = {DW{cb}}; expD[fBit] = ~cb;
    chk(failPort == fPort, "R7", "port fault port", failPort, fPort);
    chk(failAddr == fAddr && failState == 6'b001001, "R7", "port fault addr/state",
        {failState, failAddr}, {6'b001001, AW'(fAddr)});
    chk(failData == expD, "R7", "port fault data", failData, expD);

    // R9: debug mode halts per state
    fKind = 0; mode = 2'b01;
    kick();
    repeat (25) @(negedge clk);
    chk(stateCode == 6'b000001 && memWe == 0 && memRe == 0 && busy, "R9",
        "halted after first state", stateCode, 6'b000001);
    begin
      int held = 0;
      for (int s = 0; s < 22; s++) begin
        logic [5:0] c0;
        c0 = stateCode;
        repeat (3) @(negedge clk);
        if (stateCode != c0 || memWe != 0 || memRe != 0) held++;
        step = 1'b1; @(negedge clk); step = 1'b0;
        if (s == 0) chk(stateCode == 6'b001001, "R9", "step advances", stateCode, 6'b001001);
        repeat (70 + $urandom % 8) @(negedge clk);
      end
      chk(held == 0, "R9", "code held while halted", held, 0);
    end
    waitDone("R9");
    checkRun("debug R9");
    chk(pass, "R9", "debug run passes", pass, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule